// File: doc/BRIEF.md
# ADC Power Management Sequencer

This block manages power for an ADC with two converters. It runs on the ADC clock. A single control register holds the following fields:
- a manual power-down bit for each converter;
- two automatic low-power enables: full power-off and standby;
- a 6-bit warm-up delay.

The same register reads back a live power status bit for each converter. Scan requests arrive with a converter mask. The sequencer wakes any needed converter that is in a low-power state. It holds off scan start permission until the warm-up delay has elapsed, and then issues a one-cycle grant. When the scan ends, converters under automatic control go back to low power. That return waits until no scan is in flight, and it never happens while the ADC is looping.

A scan sequencer FSM has the states SC_IDLE, SC_WAKE and SC_RUN. Its transitions are:
- accept: SC_IDLE to SC_WAKE, or SC_IDLE to SC_RUN when nothing needs waking or the delay is 0;
- warm_done: SC_WAKE to SC_RUN;
- scan_end: SC_RUN to SC_IDLE.

Each converter has its own FSM with the states CV_DOWN, CV_WARM, CV_ON and CV_SLEEP. Its transitions are:
- force_down: any state to CV_DOWN on the manual bit;
- release: CV_DOWN to CV_SLEEP, CV_WARM or CV_ON;
- warm_done: CV_WARM to CV_ON;
- doze: CV_ON to CV_SLEEP;
- wake: CV_SLEEP to CV_ON on a scan;
- resume: CV_SLEEP to CV_WARM or CV_ON when automatic modes are turned off.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, rd_data reads 16'h8CD3. The register layout is: bits 1:0 manual down, bit 2 auto power-off, bit 3 auto standby, bits 9:4 delay (reset value 13), bits 11:10 status (1 = down), bit 15 always 1, and the remaining bits 0. After reset, pwr_en, stby, scan_grant and result_invalid are all 0.
- R2: A write stores bits 9:0. Bit 15 reads 1 whatever value was written.
- R3: Setting a converter's manual down bit drops its pwr_en and raises its status bit in the first cycle after the write edge.
- R4: Clearing a manual down bit while both automatic modes are off has these effects:
  - pwr_en rises one cycle after the write edge;
  - status clears D+1 cycles after the write edge, where D is the delay;
  - with D = 0, status clears one cycle after the write edge.
- R5: With auto power-off on, idle converters have pwr_en = 0. A scan request powers only the masked converters that are in low power. scan_grant is a one-cycle pulse D cycles after the edge that samples the request, or in the next cycle when D = 0.
- R6: After scan_done returns the sequencer to idle, converters under automatic control drop pwr_en one cycle later.
- R7: Under auto standby alone, sleeping converters show stby = 1 and pwr_en = 0. When auto power-off is also on, stby stays 0.
- R8: Enabling an automatic mode during a scan does not change pwr_en until that scan ends.
- R9: While loop_mode is 1, no converter enters low power. It does so one cycle after loop_mode clears.
- R10: result_invalid is high during a scan whose mask includes a manually downed converter, and low otherwise.
- R11: A scan request arriving in the cycle a converter would enter low power keeps it on. The grant then comes with no delay.
- R12: Under automatic control, the status bits follow the live powered state: 1 while a converter is asleep, 0 once it wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| scan_req | input | 1 | Scan request, sampled in idle |
| scan_mask | input | 2 | Converters the scan needs |
| scan_done | input | 1 | Scan finished |
| loop_mode | input | 1 | ADC is scanning continuously |
| scan_grant | output | 1 | One-cycle scan start permission |
| pwr_en | output | 2 | Per-converter power enable |
| stby | output | 2 | Per-converter standby |
| result_invalid | output | 1 | Current scan uses a downed converter |

## Verification
Two decisions can fall on the same edge: a converter's entry into low power in the cycle after a scan ends, and the acceptance of a new scan request. The bench ends a scan and presents the next request exactly one cycle later, so both decisions are taken on one edge. The result is judged correct when pwr_en stays high and scan_grant arrives in the next cycle with no warm-up delay. A converter that slept and was not woken would show up as a missing grant or a dropped enable.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    localparam int N_CONV = 2;
    localparam int DLY_W  = 6;
    localparam int REG_W  = 16;

    // Register field positions
    localparam int F_PD   = 0;
    localparam int F_APD  = 2;
    localparam int F_ASB  = 3;
    localparam int F_DLY  = 4;
    localparam int F_STAT = 10;
    localparam int F_RSV  = 15;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_WAKE,
        SC_RUN
    } scan_st_e;

    typedef enum logic [1:0] {
        CV_DOWN,
        CV_WARM,
        CV_ON,
        CV_SLEEP
    } conv_st_e;

    typedef struct packed {
        logic [N_CONV-1:0] pd;
        logic              apd;
        logic              asb;
        logic [DLY_W-1:0]  dly;
    } pwr_cfg_t;

endpackage

// File: rtl/adc_pwr_regs.sv
module adc_pwr_regs
    import adc_pwr_pkg::*;
#(
    parameter logic [DLY_W-1:0] DLY_RST = 6'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [N_CONV-1:0] stat,
    output pwr_cfg_t          cfg,
    output logic [REG_W-1:0]  rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.pd  <= '1;
            cfg.apd <= 1'b0;
            cfg.asb <= 1'b0;
            cfg.dly <= DLY_RST;
        end else if (wr_en) begin
            cfg.pd  <= wr_data[F_PD +: N_CONV];
            cfg.apd <= wr_data[F_APD];
            cfg.asb <= wr_data[F_ASB];
            cfg.dly <= wr_data[F_DLY +: DLY_W];
        end
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[F_PD +: N_CONV]  = cfg.pd;
        rd_data[F_APD]           = cfg.apd;
        rd_data[F_ASB]           = cfg.asb;
        rd_data[F_DLY +: DLY_W]  = cfg.dly;
        rd_data[F_STAT +: N_CONV] = stat;
        rd_data[F_RSV]           = 1'b1;
    end

endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == W'(1));

endmodule

// File: rtl/adc_pwr_conv.sv
module adc_pwr_conv
    import adc_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic             apd,
    input  logic             asb,
    input  logic [DLY_W-1:0] dly,
    input  logic             lp_ok,
    input  logic             wake,
    output logic             pwr_en,
    output logic             stby,
    output logic             status,
    output logic             sleeping,
    output logic             warming
);

    conv_st_e st, st_nxt;
    logic     auto_on;
    logic     tmr_load;
    logic     tmr_last;

    assign auto_on = apd | asb;

    adc_pwr_timer #(.W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dly),
        .last     (tmr_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= CV_DOWN;
        end else begin
            st <= st_nxt;
        end
    end

    // Next state
    always_comb begin
        st_nxt = st;
        if (pd) begin
            st_nxt = CV_DOWN;                                 // force_down
        end else begin
            unique case (st)
                CV_DOWN: begin                                // release
                    if (auto_on)           st_nxt = CV_SLEEP;
                    else if (dly == '0)    st_nxt = CV_ON;
                    else                   st_nxt = CV_WARM;
                end
                CV_WARM: begin
                    if (tmr_last)          st_nxt = CV_ON;    // warm_done
                end
                CV_ON: begin
                    if (auto_on && lp_ok)  st_nxt = CV_SLEEP; // doze
                end
                CV_SLEEP: begin
                    if (wake)              st_nxt = CV_ON;    // wake
                    else if (!auto_on) begin                  // resume
                        if (dly == '0)     st_nxt = CV_ON;
                        else               st_nxt = CV_WARM;
                    end
                end
                default:                   st_nxt = CV_DOWN;
            endcase
        end
    end

    assign tmr_load = (st_nxt == CV_WARM) && (st != CV_WARM);

    // Outputs
    always_comb begin
        pwr_en   = !pd && ((st == CV_WARM) || (st == CV_ON));
        stby     = !pd && (st == CV_SLEEP) && !apd;
        status   = pd || (st != CV_ON);
        sleeping = !pd && (st == CV_SLEEP);
        warming  = (st == CV_WARM);
    end

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter logic [DLY_W-1:0] DLY_RST = 6'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              scan_req,
    input  logic [N_CONV-1:0] scan_mask,
    input  logic              scan_done,
    input  logic              loop_mode,
    output logic              scan_grant,
    output logic [N_CONV-1:0] pwr_en,
    output logic [N_CONV-1:0] stby,
    output logic              result_invalid
);

    pwr_cfg_t          cfg;
    logic [N_CONV-1:0] stat;
    logic [N_CONV-1:0] sleeping;
    logic [N_CONV-1:0] warming;
    logic [N_CONV-1:0] wake;
    logic [N_CONV-1:0] need;
    logic [N_CONV-1:0] need_sleep;
    logic [N_CONV-1:0] mask_q;
    logic              accept;
    logic              lp_ok;
    logic              wait_load;
    logic              wait_last;
    logic              grant_q;
    scan_st_e          st, st_nxt;

    adc_pwr_regs #(.DLY_RST(DLY_RST)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .stat    (stat),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    for (genvar i = 0; i < N_CONV; i++) begin : g_conv
        adc_pwr_conv u_conv (
            .clk      (clk),
            .rst_n    (rst_n),
            .pd       (cfg.pd[i]),
            .apd      (cfg.apd),
            .asb      (cfg.asb),
            .dly      (cfg.dly),
            .lp_ok    (lp_ok),
            .wake     (wake[i]),
            .pwr_en   (pwr_en[i]),
            .stby     (stby[i]),
            .status   (stat[i]),
            .sleeping (sleeping[i]),
            .warming  (warming[i])
        );
    end

    adc_pwr_timer #(.W(DLY_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (cfg.dly),
        .last     (wait_last)
    );

    // Request qualification
    always_comb begin
        need       = scan_mask & ~cfg.pd;
        need_sleep = need & sleeping;
        accept     = (st == SC_IDLE) && scan_req && ((need & warming) == '0);
        wake       = accept ? need_sleep : '0;
        wait_load  = accept && (need_sleep != '0) && (cfg.dly != '0);
        lp_ok      = (st == SC_IDLE) && !scan_req && !loop_mode;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= SC_IDLE;
            mask_q  <= '0;
            grant_q <= 1'b0;
        end else begin
            st      <= st_nxt;
            grant_q <= (st != SC_RUN) && (st_nxt == SC_RUN);
            if (accept) begin
                mask_q <= scan_mask;
            end
        end
    end

    // Next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            SC_IDLE: begin
                if (accept) begin                       // accept
                    st_nxt = wait_load ? SC_WAKE : SC_RUN;
                end
            end
            SC_WAKE: begin
                if (wait_last) st_nxt = SC_RUN;         // warm_done
            end
            SC_RUN: begin
                if (scan_done) st_nxt = SC_IDLE;        // scan_end
            end
            default: st_nxt = SC_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        scan_grant     = grant_q;
        result_invalid = (st == SC_RUN) && ((mask_q & cfg.pd) != '0);
    end

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk
    import adc_pwr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  rd_data,
    input logic [N_CONV-1:0] pwr_en,
    input logic [N_CONV-1:0] stby,
    input logic              scan_grant,
    input logic              result_invalid
);

    for (genvar i = 0; i < N_CONV; i++) begin : g_chk
        a_r3_down_is_off: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[F_PD + i] |-> (!pwr_en[i] && !stby[i]));

        a_r12_unpowered_reads_down: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_en[i] |-> rd_data[F_STAT + i]);

        a_r7_poweroff_beats_standby: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[F_APD] |-> !stby[i]);
    end

    a_r5_grant_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        scan_grant |=> !scan_grant);

    a_r10_invalid_has_down: assert property (@(posedge clk) disable iff (!rst_n)
        result_invalid |-> (rd_data[F_PD +: N_CONV] != '0));

endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_data        (rd_data),
    .pwr_en         (pwr_en),
    .stby           (stby),
    .scan_grant     (scan_grant),
    .result_invalid (result_invalid)
);

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        scan_req = 1'b0;
    logic [1:0]  scan_mask = '0;
    logic        scan_done = 1'b0;
    logic        loop_mode = 1'b0;
    logic        scan_grant;
    logic [1:0]  pwr_en;
    logic [1:0]  stby;
    logic        result_invalid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_pwr_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .scan_req       (scan_req),
        .scan_mask      (scan_mask),
        .scan_done      (scan_done),
        .loop_mode      (loop_mode),
        .scan_grant     (scan_grant),
        .pwr_en         (pwr_en),
        .stby           (stby),
        .result_invalid (result_invalid)
    );

    function automatic logic [15:0] cfgw(input logic [1:0] pd, input logic apd,
                                         input logic asb, input logic [5:0] dly);
        return {6'b0, dly, asb, apd, pd};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic req(input logic [1:0] m);
        scan_req  = 1'b1;
        scan_mask = m;
        @(negedge clk);
        scan_req  = 1'b0;
    endtask

    task automatic fin();
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset rd_data", rd_data, 16'h8CD3);
        check("R1 reset pwr_en", 16'(pwr_en), 16'h0);
        check("R1 reset stby", 16'(stby), 16'h0);
        check("R1 reset grant", 16'(scan_grant), 16'h0);
        check("R1 reset invalid", 16'(result_invalid), 16'h0);
    endtask

    task automatic t_manual();
        wr(cfgw(2'b00, 1'b0, 1'b0, 6'd5));
        check("R2 reserved reads one", 16'(rd_data[15]), 16'h1);
        check("R2 delay field", 16'(rd_data[9:4]), 16'd5);
        step(1);
        check("R4 pwr_en next cycle", 16'(pwr_en), 16'h3);
        check("R4 status still down", 16'(rd_data[11:10]), 16'h3);
        step(4);
        check("R4 status down at D", 16'(rd_data[11:10]), 16'h3);
        step(1);
        check("R4 status up at D+1", 16'(rd_data[11:10]), 16'h0);
        wr(cfgw(2'b01, 1'b0, 1'b0, 6'd5));
        check("R3 pwr_en drops at once", 16'(pwr_en), 16'h2);
        check("R3 status rises at once", 16'(rd_data[11:10]), 16'h1);
        wr(cfgw(2'b00, 1'b0, 1'b0, 6'd0));
        step(1);
        check("R4 zero delay status", 16'(rd_data[11:10]), 16'h0);
        check("R4 zero delay pwr_en", 16'(pwr_en), 16'h3);
    endtask

    task automatic t_apd();
        wr(cfgw(2'b00, 1'b1, 1'b0, 6'd4));
        step(1);
        check("R5 idle unpowered", 16'(pwr_en), 16'h0);
        check("R12 sleeping status", 16'(rd_data[11:10]), 16'h3);
        req(2'b01);
        check("R5 only masked woken", 16'(pwr_en), 16'h1);
        check("R12 live status", 16'(rd_data[11:10]), 16'h2);
        check("R5 no grant yet", 16'(scan_grant), 16'h0);
        step(3);
        check("R5 no grant at D-1", 16'(scan_grant), 16'h0);
        step(1);
        check("R5 grant at D", 16'(scan_grant), 16'h1);
        step(1);
        check("R5 grant one cycle", 16'(scan_grant), 16'h0);
        fin();
        check("R6 still on entering idle", 16'(pwr_en), 16'h1);
        step(1);
        check("R6 off one cycle later", 16'(pwr_en), 16'h0);
        check("R12 status back down", 16'(rd_data[11:10]), 16'h3);
        wr(cfgw(2'b00, 1'b1, 1'b0, 6'd0));
        req(2'b10);
        check("R5 zero delay grant", 16'(scan_grant), 16'h1);
        check("R5 zero delay wake", 16'(pwr_en), 16'h2);
        fin();
        step(1);
    endtask

    task automatic t_asb();
        wr(cfgw(2'b00, 1'b0, 1'b1, 6'd2));
        check("R7 standby asserted", 16'(stby), 16'h3);
        check("R7 standby unpowered", 16'(pwr_en), 16'h0);
        req(2'b11);
        check("R7 standby left on wake", 16'(stby), 16'h0);
        step(1);
        check("R5 standby no grant", 16'(scan_grant), 16'h0);
        step(1);
        check("R5 standby grant at D", 16'(scan_grant), 16'h1);
        fin();
        step(1);
        check("R7 standby again", 16'(stby), 16'h3);
        wr(cfgw(2'b00, 1'b1, 1'b1, 6'd2));
        check("R7 power-off priority", 16'(stby), 16'h0);
    endtask

    task automatic t_defer();
        wr(cfgw(2'b00, 1'b0, 1'b0, 6'd1));
        step(3);
        check("R8 powered before scan", 16'(pwr_en), 16'h3);
        req(2'b11);
        check("R8 grant without wake", 16'(scan_grant), 16'h1);
        wr(cfgw(2'b00, 1'b1, 1'b0, 6'd1));
        step(2);
        check("R8 scan unaffected", 16'(pwr_en), 16'h3);
        fin();
        step(1);
        check("R8 low power after scan", 16'(pwr_en), 16'h0);
    endtask

    task automatic t_loop();
        loop_mode = 1'b1;
        req(2'b01);
        step(1);
        check("R9 grant in loop", 16'(scan_grant), 16'h1);
        fin();
        step(3);
        check("R9 loop keeps power", 16'(pwr_en), 16'h1);
        loop_mode = 1'b0;
        step(1);
        check("R9 sleeps after loop ends", 16'(pwr_en), 16'h0);
    endtask

    task automatic t_invalid();
        wr(cfgw(2'b10, 1'b0, 1'b0, 6'd0));
        step(1);
        req(2'b11);
        check("R10 grant", 16'(scan_grant), 16'h1);
        check("R10 invalid with downed", 16'(result_invalid), 16'h1);
        fin();
        step(1);
        check("R10 invalid clears idle", 16'(result_invalid), 16'h0);
        req(2'b01);
        check("R10 valid scan", 16'(result_invalid), 16'h0);
        fin();
    endtask

    task automatic t_race();
        wr(cfgw(2'b00, 1'b1, 1'b0, 6'd3));
        step(1);
        req(2'b01);
        step(2);
        check("R11 setup no grant", 16'(scan_grant), 16'h0);
        step(1);
        check("R11 setup grant", 16'(scan_grant), 16'h1);
        fin();
        req(2'b01);
        check("R11 immediate grant", 16'(scan_grant), 16'h1);
        check("R11 converter kept on", 16'(pwr_en), 16'h1);
        fin();
        step(1);
        check("R11 sleeps afterwards", 16'(pwr_en), 16'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_manual();
        t_apd();
        t_asb();
        t_defer();
        t_loop();
        t_invalid();
        t_race();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule